// File: doc/BRIEF.md
# Time-of-Day Target Compare Unit

This block watches a free-running time-of-day value, given as whole seconds plus a nanoseconds count, and compares it with a target time that software programs. When the time reaches the target, a sticky "reached" flag sets. If the target is already behind the current time when it is committed, a sticky "late target" flag sets instead, and the compare is not armed. A third sticky flag records that the seconds count wrapped from its all-ones value to zero.

Software reaches the block through a small register port with four word addresses. Writing the target seconds disarms the compare. Writing a valid target nanoseconds value commits the target and arms it. The three flags share one status word. A control bit picks how they clear: either a status read clears them all, or only a write of 1 to a flag bit clears it. A level interrupt is the OR of the flags, each gated by its own enable bit.

Top module: `tod_alarm_unit`

## Requirements
- R1: After a synchronous active-low reset, all flags are 0, `irq` is 0, the compare is disarmed, and the target and control registers read 0.
- R2: The register map is as follows. Address 0 is target seconds. Address 1 is target nanoseconds, in bits 29:0. Address 2 is status: bit 0 reached, bit 1 late target, bit 2 seconds wrap. Address 3 is control: bit 0 selects write-1-to-clear mode, and bits 1, 2 and 3 enable the interrupt for reached, late and wrap. `reg_rdata` shows the addressed register in the same cycle, with unused bits 0.
- R3: While armed, the reached flag is set at the clock edge at which the time is at or beyond the target. The seconds are compared first, and the nanoseconds decide only when the seconds are equal.
- R4: A valid write to address 1 arms the compare, and a write to address 0 disarms it. Once reached has fired, the compare stays disarmed, so reached sets at most once per committed target.
- R5: If the time at the committing write is already at or beyond the new target, the late flag is set at that edge and the compare stays disarmed, so reached does not set for that target.
- R6: A write to address 1 with a value of 1,000,000,000 or more is ignored. The nanoseconds register and the arm state do not change.
- R7: The wrap flag is set when `tod_sec` is all ones in one cycle and 0 in the next.
- R8: In read-clear mode (control bit 0 = 0), a read of address 2 returns the flags as they were before the read and clears all of them at that edge. Writes to address 2 have no effect in this mode.
- R9: In write-1-to-clear mode (control bit 0 = 1), reads of address 2 clear nothing. A write to address 2 clears exactly the flags whose data bits are 1.
- R10: A hardware set and a software clear of the same flag in the same cycle leave the flag set.
- R11: `irq` is high exactly when some flag is set and its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tod_sec | input | 32 | Current time, seconds |
| tod_ns | input | 30 | Current time, nanoseconds |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read-clear) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle |
| irq | output | 1 | Level interrupt |

## Verification
The compare is driven with times one nanosecond short of the target and exactly on it. It is also driven with a seconds value that is lower while the nanoseconds are higher, and with a seconds value that is higher while the nanoseconds are lower. Together these show that the order is seconds-first and that equality counts as reached. A target committed behind the time separates the late path from the reached path. An out-of-range nanoseconds write made while armed shows that neither the register nor the armed compare was disturbed. A status read issued in the very cycle the time crosses the target shows whether set beats clear. Flags raised under both clear modes show which action clears which bit.

// File: rtl/tod_alarm_pkg.sv
// Package: shared register addresses, flag indices and control bit positions
// for the time-of-day target compare unit.
package tod_alarm_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_TGT_SEC = 2'd0,
        REG_TGT_NS  = 2'd1,
        REG_STATUS  = 2'd2,
        REG_CTRL    = 2'd3
    } reg_addr_e;

    localparam int N_FLAGS     = 3;
    localparam int FLG_REACHED = 0;
    localparam int FLG_LATE    = 1;
    localparam int FLG_WRAP    = 2;

    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_EN_LSB   = 1;
endpackage

// File: rtl/tod_ge_cmp.sv
// Module: tod_ge_cmp
// Reports whether time A is at or after time B. Both times are given as
// seconds plus nanoseconds. Assumes both nanosecond fields are already below
// one second, so comparing the seconds first and then the nanoseconds gives
// the true order.
module tod_ge_cmp #(
    parameter int SEC_W = 32,
    parameter int NS_W  = 30
) (
    input  logic [SEC_W-1:0] a_sec,
    input  logic [NS_W-1:0]  a_ns,
    input  logic [SEC_W-1:0] b_sec,
    input  logic [NS_W-1:0]  b_ns,
    output logic             a_ge_b
);
    // Seconds decide; the nanoseconds break a tie only.
    always_comb begin
        if (a_sec != b_sec) a_ge_b = (a_sec > b_sec);
        else                a_ge_b = (a_ns >= b_ns);
    end
endmodule

// File: rtl/sec_wrap_detect.sv
// Module: sec_wrap_detect
// Flags the cycle in which the seconds input steps from all ones to zero.
// Assumes the seconds input is sampled every cycle. The first cycle after
// reset never flags, because there is no earlier sample to compare with yet.
module sec_wrap_detect #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sec,
    output logic             wrap
);
    logic [SEC_W-1:0] prev_sec;
    logic             prev_valid;

    // Remember last cycle's seconds and whether that sample is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sec   <= '0;
            prev_valid <= 1'b0;
        end else begin
            prev_sec   <= sec;
            prev_valid <= 1'b1;
        end
    end

    // Wrap: previous sample all ones, current sample zero.
    always_comb wrap = prev_valid && (&prev_sec) && (sec == '0);
endmodule

// File: rtl/flag_cell.sv
// Module: flag_cell
// One sticky status bit. A set always wins over a clear in the same cycle.
// Assumes the set and clear inputs are single-cycle requests.
module flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/tod_alarm_unit.sv
// Module: tod_alarm_unit (top)
// Compares a free-running time of day with a committed target time. It keeps
// the reached, late-target and seconds-wrap flags as sticky bits, clears them
// either on a status read or by writing 1 (picked by a control bit), and drives
// a gated level interrupt. Assumes the time input is valid (nanoseconds below
// NS_LIMIT) and that SEC_W is at least NS_W and at least N_FLAGS + 1.
module tod_alarm_unit
    import tod_alarm_pkg::*;
#(
    parameter int SEC_W    = 32,
    parameter int NS_W     = 30,
    parameter int NS_LIMIT = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  tod_sec,
    input  logic [NS_W-1:0]   tod_ns,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SEC_W-1:0]  reg_wdata,
    output logic [SEC_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int                NS_PAD  = SEC_W - NS_W;
    localparam int                FLG_PAD = SEC_W - N_FLAGS;
    localparam int                CTL_PAD = SEC_W - N_FLAGS - 1;
    localparam logic [SEC_W-1:0]  NS_MAX  = SEC_W'(NS_LIMIT);

    reg_addr_e          addr;
    logic [SEC_W-1:0]   tgt_sec;
    logic [NS_W-1:0]    tgt_ns;
    logic               armed;
    logic               clr_mode_w1c;
    logic [N_FLAGS-1:0] irq_en;
    logic [N_FLAGS-1:0] flags;
    logic [N_FLAGS-1:0] set_vec;
    logic [N_FLAGS-1:0] clr_vec;

    logic wr_sec, wr_ns_any, ns_ok, commit, wr_stat, rd_stat, wr_ctrl;
    logic ge_live, late, hit, wrap;

    // Decode the register strobes.
    always_comb begin
        addr      = reg_addr_e'(reg_addr);
        wr_sec    = reg_wr && (addr == REG_TGT_SEC);
        wr_ns_any = reg_wr && (addr == REG_TGT_NS);
        wr_stat   = reg_wr && (addr == REG_STATUS);
        wr_ctrl   = reg_wr && (addr == REG_CTRL);
        rd_stat   = reg_rd && (addr == REG_STATUS);
        ns_ok     = (reg_wdata < NS_MAX);
        commit    = wr_ns_any && ns_ok;
    end

    // Live compare: current time against the held target.
    tod_ge_cmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp_live (
        .a_sec (tod_sec),
        .a_ns  (tod_ns),
        .b_sec (tgt_sec),
        .b_ns  (tgt_ns),
        .a_ge_b(ge_live)
    );

    // Commit-time compare: current time against the target being written.
    tod_ge_cmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp_commit (
        .a_sec (tod_sec),
        .a_ns  (tod_ns),
        .b_sec (tgt_sec),
        .b_ns  (reg_wdata[NS_W-1:0]),
        .a_ge_b(late)
    );

    sec_wrap_detect #(.SEC_W(SEC_W)) u_wrap (
        .clk  (clk),
        .rst_n(rst_n),
        .sec  (tod_sec),
        .wrap (wrap)
    );

    // Reached fires only on an armed target that is not being rewritten.
    always_comb hit = armed && ge_live && !wr_sec && !commit;

    // Target and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_sec      <= '0;
            tgt_ns       <= '0;
            clr_mode_w1c <= 1'b0;
            irq_en       <= '0;
        end else begin
            if (wr_sec) tgt_sec <= reg_wdata;
            if (commit) tgt_ns  <= reg_wdata[NS_W-1:0];
            if (wr_ctrl) begin
                clr_mode_w1c <= reg_wdata[CTRL_MODE_BIT];
                irq_en       <= reg_wdata[CTRL_EN_LSB +: N_FLAGS];
            end
        end
    end

    // Arm state: disarm on a seconds write, arm on a timely commit, drop after firing.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (wr_sec) armed <= 1'b0;
        else if (commit) armed <= !late;
        else if (hit)    armed <= 1'b0;
    end

    // Hardware set requests and software clear requests for each flag.
    always_comb begin
        set_vec              = '0;
        set_vec[FLG_REACHED] = hit;
        set_vec[FLG_LATE]    = commit && late;
        set_vec[FLG_WRAP]    = wrap;
        if (clr_mode_w1c) clr_vec = wr_stat ? reg_wdata[N_FLAGS-1:0] : '0;
        else              clr_vec = rd_stat ? '1 : '0;
    end

    for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_flag
        flag_cell u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[gi]),
            .clr_i (clr_vec[gi]),
            .flag_o(flags[gi])
        );
    end

    // Read-back multiplexer, combinational.
    always_comb begin
        unique case (addr)
            REG_TGT_SEC: reg_rdata = tgt_sec;
            REG_TGT_NS:  reg_rdata = {{NS_PAD{1'b0}}, tgt_ns};
            REG_STATUS:  reg_rdata = {{FLG_PAD{1'b0}}, flags};
            default:     reg_rdata = {{CTL_PAD{1'b0}}, irq_en, clr_mode_w1c};
        endcase
    end

    // Level interrupt from the enabled flags.
    always_comb irq = |(flags & irq_en);

    assert_reach_on_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_REACHED]) |-> $past(armed && ge_live));

    assert_fire_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !armed);

    assert_late_no_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && late) |=> !armed);

    assert_bad_ns_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ns_any && !ns_ok) |=> $stable(tgt_ns));

    assert_wrap_from_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_WRAP]) |-> $past(tod_sec == '0));

    assert_w1c_read_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mode_w1c && rd_stat && !wr_stat) |=> (($past(flags) & ~flags) == '0));

    assert_irq_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
endmodule

// File: tb/tod_alarm_unit_bench.sv
// Bench for tod_alarm_unit. A behavioural model kept as plain integers is
// compared with the outputs on every clock, and directed checks target each
// requirement.
module tod_alarm_unit_bench;
    localparam time CLK_P = 8ns;
    localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] tod_sec;
    logic [29:0] tod_ns;
    logic        reg_wr, reg_rd;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    tod_alarm_unit u_tod_alarm_unit (
        .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_ns(tod_ns),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    longint unsigned m_tsec, m_tns, m_prev;
    bit              m_armed, m_mode, m_pv;
    bit [2:0]        m_flags, m_en, m_set, m_clr;
    bit              m_late, m_commit, m_hit, m_wrap;

    function automatic longint unsigned as_ns(input longint unsigned s, input longint unsigned n);
        return s * NS_PER_S + n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tsec = 0; m_tns = 0; m_prev = 0; m_armed = 0; m_mode = 0;
            m_pv = 0; m_flags = 0; m_en = 0;
        end else begin
            m_late   = as_ns(tod_sec, tod_ns) >= as_ns(m_tsec, reg_wdata[29:0]);
            m_commit = reg_wr && reg_addr == 2'd1 && reg_wdata < 32'd1_000_000_000;
            m_hit    = m_armed && (as_ns(tod_sec, tod_ns) >= as_ns(m_tsec, m_tns))
                       && !(reg_wr && reg_addr == 2'd0) && !m_commit;
            m_wrap   = m_pv && m_prev == 64'hFFFF_FFFF && tod_sec == 0;
            m_set    = {m_wrap, m_commit && m_late, m_hit};
            if (m_mode) m_clr = (reg_wr && reg_addr == 2'd2) ? reg_wdata[2:0] : 3'b000;
            else        m_clr = (reg_rd && reg_addr == 2'd2) ? 3'b111 : 3'b000;
            m_flags = m_set | (m_flags & ~m_clr);
            if (reg_wr && reg_addr == 2'd0) m_armed = 0;
            else if (m_commit)              m_armed = !m_late;
            else if (m_hit)                 m_armed = 0;
            if (reg_wr && reg_addr == 2'd0) m_tsec = reg_wdata;
            if (m_commit)                   m_tns  = reg_wdata[29:0];
            if (reg_wr && reg_addr == 2'd3) begin
                m_mode = reg_wdata[0];
                m_en   = reg_wdata[3:1];
            end
            m_prev = tod_sec;
            m_pv   = 1;
        end
    end

    function automatic logic [31:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_tsec[31:0];
            2'd1:    return {2'b00, m_tns[29:0]};
            2'd2:    return {29'd0, m_flags};
            default: return {28'd0, m_en, m_mode};
        endcase
    endfunction

    // Per-clock comparison against the model, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            chk("R11 model irq", {31'd0, irq}, {31'd0, |(m_flags & m_en)});
            chk("R2 model rdata", reg_rdata, m_rdata(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        tick();
    endtask

    task automatic set_tod(input logic [31:0] s, input logic [29:0] n);
        tod_sec = s; tod_ns = n;
        tick();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; tod_sec = '0; tod_ns = '0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (4) tick();
        rst_n = 1'b1;

        // R1: reset state
        peek(2'd2, d); chk("R1 status after reset", d, 32'd0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        peek(2'd0, d); chk("R1 target sec after reset", d, 32'd0);
        peek(2'd3, d); chk("R1 control after reset", d, 32'd0);

        // Enable all interrupts, read-clear mode.
        wr(2'd3, 32'hE);
        peek(2'd3, d); chk("R2 control readback", d, 32'hE);

        // R3: equality reaches, one short does not.
        tod_sec = 32'd10; tod_ns = 30'd500;
        wr(2'd0, 32'd10);
        wr(2'd1, 32'd600);
        set_tod(32'd10, 30'd599);
        peek(2'd2, d); chk("R3 one ns short", d, 32'd0);
        set_tod(32'd10, 30'd600);
        peek(2'd2, d); chk("R3 reached on equality", d, 32'd1);
        chk("R11 irq with reached enabled", {31'd0, irq}, 32'd1);

        // R8: read returns old value and clears.
        rd(2'd2, d); chk("R8 read returns flags", d, 32'd1);
        peek(2'd2, d); chk("R8 cleared by read", d, 32'd0);

        // R4: fires once per target.
        set_tod(32'd10, 30'd700);
        peek(2'd2, d); chk("R4 no refire", d, 32'd0);

        // R3: seconds first.
        wr(2'd0, 32'd11);
        wr(2'd1, 32'd100);
        set_tod(32'd10, 30'd999_999_999);
        peek(2'd2, d); chk("R3 lower sec higher ns", d, 32'd0);
        set_tod(32'd11, 30'd50);
        peek(2'd2, d); chk("R3 equal sec lower ns", d, 32'd0);
        set_tod(32'd11, 30'd100);
        peek(2'd2, d); chk("R3 equal sec equal ns", d, 32'd1);
        rd(2'd2, d);
        wr(2'd0, 32'd12);
        wr(2'd1, 32'd500);
        set_tod(32'd13, 30'd0);
        peek(2'd2, d); chk("R3 higher sec lower ns", d, 32'd1);
        rd(2'd2, d);

        // R5: target already in the past.
        wr(2'd0, 32'd5);
        wr(2'd1, 32'd0);
        peek(2'd2, d); chk("R5 late flag", d, 32'd2);
        set_tod(32'd13, 30'd10);
        peek(2'd2, d); chk("R5 no reached for late target", d, 32'd2);
        rd(2'd2, d);

        // R6: out-of-range nanoseconds ignored while armed.
        wr(2'd0, 32'd20);
        wr(2'd1, 32'd400);
        wr(2'd1, 32'd1_000_000_000);
        peek(2'd1, d); chk("R6 ns register kept", d, 32'd400);
        set_tod(32'd20, 30'd400);
        peek(2'd2, d); chk("R6 still armed", d, 32'd1);
        rd(2'd2, d);

        // R7: seconds wrap.
        set_tod(32'hFFFF_FFFF, 30'd5);
        peek(2'd2, d); chk("R7 no wrap yet", d, 32'd0);
        set_tod(32'd0, 30'd5);
        peek(2'd2, d); chk("R7 wrap flag", d, 32'd4);
        rd(2'd2, d);

        // R10: read-clear in the cycle the target is reached.
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd100);
        tod_sec = 32'd0; tod_ns = 30'd100;
        rd(2'd2, d); chk("R10 read before set", d, 32'd0);
        peek(2'd2, d); chk("R10 set beats clear", d, 32'd1);
        rd(2'd2, d);

        // R9: write-1-to-clear mode.
        wr(2'd3, 32'hF);
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd0);
        set_tod(32'hFFFF_FFFF, 30'd0);
        set_tod(32'd0, 30'd0);
        rd(2'd2, d); chk("R9 read shows flags", d, 32'd6);
        peek(2'd2, d); chk("R9 read does not clear", d, 32'd6);
        wr(2'd2, 32'd2);
        peek(2'd2, d); chk("R9 write 1 clears one bit", d, 32'd4);
        wr(2'd2, 32'd4);
        peek(2'd2, d); chk("R9 write clears last bit", d, 32'd0);

        // R8: writes ignored in read-clear mode.
        wr(2'd3, 32'hE);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd7);
        peek(2'd2, d); chk("R8 write ignored in read-clear mode", d, 32'd2);
        rd(2'd2, d);

        // R11: enable gating.
        wr(2'd3, 32'h0);
        wr(2'd1, 32'd0);
        peek(2'd2, d); chk("R11 flag present", d, 32'd2);
        chk("R11 irq gated off", {31'd0, irq}, 32'd0);
        wr(2'd3, 32'h4);
        chk("R11 irq with late enabled", {31'd0, irq}, 32'd1);

        repeat (3) tick();
        summary();
        $finish;
    end
endmodule